// File: doc/BRIEF.md
# Dual-Sided Channel Mailbox with Host Interrupts

This block is the I/O-processor side of a message mailbox kept in shared RAM. It has seven send channels and seven receive channels. Each channel holds one 32-byte message buffer and one state byte. A host and a local processor each reach the whole mailbox through their own byte port. Each port has a write strobe, an address, write data and registered read data.

Traffic on every channel follows a four-step state sequence. On a send channel the host posts a message, and the local processor picks it up and marks it done. On a receive channel the roles are reversed. The block watches the state-byte writes that the local processor makes. It raises a sticky "send complete" flag and a sticky "receive new" flag, and drives one combined host interrupt line. A separate doorbell input lets the host get the local processor's attention. It sets a pending flag that only the local side can clear.

The address map, with default parameters and 10-bit addresses, is as follows:
- Send buffers: channel n, byte i at n*32+i.
- Receive buffers: 256+n*32+i.
- Send state bytes: 512+n.
- Receive state bytes: 520+n.
- Status byte: 528. Bit 0 is the send-complete flag, bit 1 is the receive-new flag and bit 2 is doorbell pending.

Channel slot 7 and every other address are unmapped.

Top module: `mbx_mailbox`

## Requirements
- R1: During and after reset every state byte reads 0 (IDLE), and int0, int1, h_irq and l_attn are 0.
- R2: A byte written by either port at a send-buffer address (n*32+i) or a receive-buffer address (256+n*32+i) for channel n < 7 reads back unchanged on both ports. This lets a reply be written back into the buffer that carried the message.
- R3: Each state byte (send at 512+n, receive at 520+n) stores any 8-bit value written by either port and reads it back on both ports. The encodings are IDLE=0, NEW=1, RCVD=2 and COMPLETE=3.
- R4: A local-port write of COMPLETE (3) to a send state byte sets int0. A local write of any other value to a send state byte, or of COMPLETE to a receive state byte, leaves int0 unchanged.
- R5: A local-port write of NEW (1) to a receive state byte sets int1. A local write of any other value to a receive state byte leaves int1 unchanged.
- R6: Host-port writes to state bytes never set int0 or int1.
- R7: int0 and int1 stay set until the host writes the status byte with a 1 in bit 0 or bit 1 respectively. Bits written as 0 leave their flag unchanged. A set event in the same cycle as a clear leaves the flag set.
- R8: h_irq is 1 exactly when int0 or int1 is 1.
- R9: A doorbell pulse sets l_attn (status bit 2). Only a local-port write of the status byte with bit 2 set clears it. A host write of bit 2 has no effect.
- R10: When both ports write the same location in one cycle, the local port's data is stored.
- R11: Writes to unmapped addresses, including channel slot 7 of any area, are ignored. Reads of them return 0, and a local COMPLETE write to send slot 7 (519) does not set int0.
- R12: Read data for the address presented in one cycle appears on that port's rdata after the next rising clock edge. A write in the same cycle as a read of the same address returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 10 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, one cycle after address |
| l_we | input | 1 | Local processor write strobe |
| l_addr | input | 10 | Local processor byte address |
| l_wdata | input | 8 | Local processor write data |
| l_rdata | output | 8 | Local processor read data, one cycle after address |
| doorbell | input | 1 | Host doorbell pulse |
| int0 | output | 1 | Send-complete flag |
| int1 | output | 1 | Receive-new flag |
| h_irq | output | 1 | Host interrupt line, OR of both flags |
| l_attn | output | 1 | Doorbell pending toward the local processor |

## Verification
The assertions check the following on every cycle:
- A local COMPLETE write to a send state byte, or a local NEW write to a receive state byte, sets the matching flag on the next edge.
- int0 only rises after such a write.
- The flags persist unless the host clears them.
- The doorbell sets the attention flag.
- The interrupt line tracks the two flags.

Only the bench scenarios can show the rest:
- Buffer and state contents round-trip between the two ports.
- Local-wins collisions on shared locations.
- Set-over-clear in a single cycle.
- Unmapped slots that store nothing.
- Host writes of trigger values that have no effect on the flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [7:0] {
    ST_IDLE = 8'd0,
    ST_NEW  = 8'd1,
    ST_RCVD = 8'd2,
    ST_DONE = 8'd3
  } mstate_e;

  typedef enum logic [2:0] {
    RG_NONE    = 3'd0,
    RG_BUF     = 3'd1,
    RG_SEND_ST = 3'd2,
    RG_RECV_ST = 3'd3,
    RG_STATUS  = 3'd4
  } region_e;

  localparam int FLG_SEND_DONE = 0;
  localparam int FLG_RECV_NEW  = 1;
  localparam int FLG_ATTN      = 2;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int NCH       = 7,
  parameter int MSG_BYTES = 32,
  localparam int CH_W   = $clog2(NCH + 1),
  localparam int MB_W   = $clog2(MSG_BYTES),
  localparam int BUF_AW = 1 + CH_W + MB_W,
  localparam int AW     = BUF_AW + 1
) (
  input  logic [AW-1:0]   addr,
  output region_e         region,
  output logic [CH_W-1:0] ch
);
  localparam logic [BUF_AW-1:0] SLOTS = BUF_AW'(2 ** CH_W);
  localparam logic [CH_W-1:0]   NCH_V = CH_W'(NCH);

  logic [BUF_AW-1:0] off;
  assign off = addr[BUF_AW-1:0];

  always_comb begin
    region = RG_NONE;
    ch     = '0;
    if (!addr[AW-1]) begin
      ch = addr[BUF_AW-2 -: CH_W];
      if (ch < NCH_V) region = RG_BUF;
    end else if (off < SLOTS) begin
      ch = off[CH_W-1:0];
      if (ch < NCH_V) region = RG_SEND_ST;
    end else if (off < (SLOTS << 1)) begin
      ch = off[CH_W-1:0];
      if (ch < NCH_V) region = RG_RECV_ST;
    end else if (off == (SLOTS << 1)) begin
      region = RG_STATUS;
    end
  end
endmodule

// File: rtl/mbx_buf_ram.sv
module mbx_buf_ram #(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  logic [DW-1:0] mem [DEPTH];

  // port b is written last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/mbx_state_bank.sv
module mbx_state_bank
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CH_W = $clog2(NCH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_we,
  input  region_e             h_reg,
  input  logic [CH_W-1:0]     h_ch,
  input  logic [7:0]          h_wd,
  input  logic                l_we,
  input  region_e             l_reg,
  input  logic [CH_W-1:0]     l_ch,
  input  logic [7:0]          l_wd,
  output logic [NCH-1:0][7:0] send_st,
  output logic [NCH-1:0][7:0] recv_st,
  output logic                ev_send_done,
  output logic                ev_recv_new
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic l_hit_s, h_hit_s, l_hit_r, h_hit_r;
    assign l_hit_s = l_we && (l_reg == RG_SEND_ST) && (l_ch == CH_W'(c));
    assign h_hit_s = h_we && (h_reg == RG_SEND_ST) && (h_ch == CH_W'(c));
    assign l_hit_r = l_we && (l_reg == RG_RECV_ST) && (l_ch == CH_W'(c));
    assign h_hit_r = h_we && (h_reg == RG_RECV_ST) && (h_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        send_st[c] <= ST_IDLE;
        recv_st[c] <= ST_IDLE;
      end else begin
        if (l_hit_s)      send_st[c] <= l_wd;
        else if (h_hit_s) send_st[c] <= h_wd;
        if (l_hit_r)      recv_st[c] <= l_wd;
        else if (h_hit_r) recv_st[c] <= h_wd;
      end
    end
  end

  // only the far (local) side raises host-visible events
  assign ev_send_done = l_we && (l_reg == RG_SEND_ST) && (l_wd == ST_DONE);
  assign ev_recv_new  = l_we && (l_reg == RG_RECV_ST) && (l_wd == ST_NEW);
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic clk,
  input  logic rst,
  input  logic ev_send_done,
  input  logic ev_recv_new,
  input  logic ring,
  input  logic clr_send,
  input  logic clr_recv,
  input  logic clr_attn,
  output logic f_send,
  output logic f_recv,
  output logic f_attn,
  output logic irq
);
  logic n_send, n_recv;
  assign n_send = ev_send_done | (f_send & ~clr_send);
  assign n_recv = ev_recv_new  | (f_recv & ~clr_recv);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_send <= 1'b0;
      f_recv <= 1'b0;
      f_attn <= 1'b0;
      irq    <= 1'b0;
    end else begin
      f_send <= n_send;
      f_recv <= n_recv;
      f_attn <= ring | (f_attn & ~clr_attn);
      irq    <= n_send | n_recv;
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int NCH       = 7,
  parameter int MSG_BYTES = 32,
  localparam int CH_W   = $clog2(NCH + 1),
  localparam int MB_W   = $clog2(MSG_BYTES),
  localparam int BUF_AW = 1 + CH_W + MB_W,
  localparam int AW     = BUF_AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [7:0]    l_wdata,
  output logic [7:0]    l_rdata,
  input  logic          doorbell,
  output logic          int0,
  output logic          int1,
  output logic          h_irq,
  output logic          l_attn
);
  localparam int NP = 2;  // 0 = host, 1 = local

  logic [AW-1:0]   p_addr [NP];
  logic            p_we   [NP];
  logic [7:0]      p_wd   [NP];
  region_e         p_reg  [NP];
  logic [CH_W-1:0] p_ch   [NP];
  logic [7:0]      p_ram  [NP];
  logic [7:0]      p_aux  [NP];
  logic            p_selq [NP];
  logic [7:0]      p_auxq [NP];

  assign p_addr[0] = h_addr;  assign p_we[0] = h_we;  assign p_wd[0] = h_wdata;
  assign p_addr[1] = l_addr;  assign p_we[1] = l_we;  assign p_wd[1] = l_wdata;

  logic [NCH-1:0][7:0] send_st, recv_st;
  logic ev_send_done, ev_recv_new;
  logic [7:0] status_b;

  for (genvar p = 0; p < NP; p++) begin : g_port
    mbx_addr_dec #(.NCH(NCH), .MSG_BYTES(MSG_BYTES)) u_dec (
      .addr(p_addr[p]), .region(p_reg[p]), .ch(p_ch[p])
    );

    always_comb begin
      unique case (p_reg[p])
        RG_SEND_ST: p_aux[p] = send_st[p_ch[p]];
        RG_RECV_ST: p_aux[p] = recv_st[p_ch[p]];
        RG_STATUS:  p_aux[p] = status_b;
        default:    p_aux[p] = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        p_selq[p] <= 1'b0;
        p_auxq[p] <= '0;
      end else begin
        p_selq[p] <= (p_reg[p] == RG_BUF);
        p_auxq[p] <= p_aux[p];
      end
    end
  end

  mbx_buf_ram #(.AW(BUF_AW), .DW(8)) u_ram (
    .clk   (clk),
    .a_we  (h_we && (p_reg[0] == RG_BUF)),
    .a_addr(h_addr[BUF_AW-1:0]),
    .a_wd  (h_wdata),
    .a_rd  (p_ram[0]),
    .b_we  (l_we && (p_reg[1] == RG_BUF)),
    .b_addr(l_addr[BUF_AW-1:0]),
    .b_wd  (l_wdata),
    .b_rd  (p_ram[1])
  );

  mbx_state_bank #(.NCH(NCH)) u_st (
    .clk(clk), .rst(rst),
    .h_we(p_we[0]), .h_reg(p_reg[0]), .h_ch(p_ch[0]), .h_wd(p_wd[0]),
    .l_we(p_we[1]), .l_reg(p_reg[1]), .l_ch(p_ch[1]), .l_wd(p_wd[1]),
    .send_st(send_st), .recv_st(recv_st),
    .ev_send_done(ev_send_done), .ev_recv_new(ev_recv_new)
  );

  logic h_stw, l_stw;
  assign h_stw = h_we && (p_reg[0] == RG_STATUS);
  assign l_stw = l_we && (p_reg[1] == RG_STATUS);

  mbx_flags u_flg (
    .clk(clk), .rst(rst),
    .ev_send_done(ev_send_done), .ev_recv_new(ev_recv_new), .ring(doorbell),
    .clr_send(h_stw && h_wdata[FLG_SEND_DONE]),
    .clr_recv(h_stw && h_wdata[FLG_RECV_NEW]),
    .clr_attn(l_stw && l_wdata[FLG_ATTN]),
    .f_send(int0), .f_recv(int1), .f_attn(l_attn), .irq(h_irq)
  );

  always_comb begin
    status_b = '0;
    status_b[FLG_SEND_DONE] = int0;
    status_b[FLG_RECV_NEW]  = int1;
    status_b[FLG_ATTN]      = l_attn;
  end

  assign h_rdata = p_selq[0] ? p_ram[0] : p_auxq[0];
  assign l_rdata = p_selq[1] ? p_ram[1] : p_auxq[1];
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int NCH       = 7,
  parameter int MSG_BYTES = 32,
  localparam int CH_W   = $clog2(NCH + 1),
  localparam int MB_W   = $clog2(MSG_BYTES),
  localparam int AW     = 2 + CH_W + MB_W
) (
  input logic          clk,
  input logic          rst,
  input logic          h_we,
  input logic [AW-1:0] h_addr,
  input logic [7:0]    h_wdata,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic [7:0]    l_wdata,
  input logic          doorbell,
  input logic          int0,
  input logic          int1,
  input logic          h_irq,
  input logic          l_attn
);
  region_e         hr, lr;
  logic [CH_W-1:0] hc, lc;

  mbx_addr_dec #(.NCH(NCH), .MSG_BYTES(MSG_BYTES)) u_hd (.addr(h_addr), .region(hr), .ch(hc));
  mbx_addr_dec #(.NCH(NCH), .MSG_BYTES(MSG_BYTES)) u_ld (.addr(l_addr), .region(lr), .ch(lc));

  logic l_done_w, l_new_w, h_clr0;
  assign l_done_w = l_we && (lr == RG_SEND_ST) && (l_wdata == 8'd3);
  assign l_new_w  = l_we && (lr == RG_RECV_ST) && (l_wdata == 8'd1);
  assign h_clr0   = h_we && (hr == RG_STATUS) && h_wdata[0];

  p_done_sets_int0_r4: assert property (@(posedge clk) disable iff (rst)
    l_done_w |=> int0);

  p_new_sets_int1_r5: assert property (@(posedge clk) disable iff (rst)
    l_new_w |=> int1);

  p_int0_only_by_local_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(int0) |-> $past(l_done_w));

  p_int0_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (int0 && !h_clr0) |=> int0);

  p_irq_or_r8: assert property (@(posedge clk) disable iff (rst)
    h_irq == (int0 || int1));

  p_doorbell_attn_r9: assert property (@(posedge clk) disable iff (rst)
    doorbell |=> l_attn);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.NCH(NCH), .MSG_BYTES(MSG_BYTES)) u_chk (
  .clk(clk), .rst(rst), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .doorbell(doorbell),
  .int0(int0), .int1(int1), .h_irq(h_irq), .l_attn(l_attn)
);

// File: tb/sim_mbx_mailbox.sv
module sim_mbx_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic h_we = 0, l_we = 0, doorbell = 0;
  logic [AW-1:0] h_addr = '0, l_addr = '0;
  logic [7:0] h_wdata = '0, l_wdata = '0, h_rdata, l_rdata;
  logic int0, int1, h_irq, l_attn;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_mailbox u0 (
    .clk(clk), .rst(rst), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .doorbell(doorbell), .int0(int0), .int1(int1),
    .h_irq(h_irq), .l_attn(l_attn)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    port;   // 0 host, 1 local
    logic [7:0] exp;
    string tag;
  } item_t;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected reads once their data is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.port ? l_rdata : h_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: %s rdata actual=%02h expected=%02h", it.tag,
                 it.port ? "local" : "host", act, it.exp);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic hw(input int a, input logic [7:0] d);
    @(negedge clk); h_we = 1; h_addr = AW'(a); h_wdata = d;
    @(negedge clk); h_we = 0;
  endtask

  task automatic lw(input int a, input logic [7:0] d);
    @(negedge clk); l_we = 1; l_addr = AW'(a); l_wdata = d;
    @(negedge clk); l_we = 0;
  endtask

  task automatic both(input int ha, input logic [7:0] hd, input int la, input logic [7:0] ld);
    @(negedge clk); h_we = 1; h_addr = AW'(ha); h_wdata = hd;
    l_we = 1; l_addr = AW'(la); l_wdata = ld;
    @(negedge clk); h_we = 0; l_we = 0;
  endtask

  task automatic rd(input bit port, input int a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    if (port) l_addr = AW'(a); else h_addr = AW'(a);
    it.due = cyc + 1; it.port = port; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1;
    @(negedge clk); doorbell = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: flags during reset
    @(negedge clk);
    chk(int0, 0, "R1 int0 in reset"); chk(h_irq, 0, "R1 h_irq in reset");
    rst = 0;
    @(negedge clk);
    chk(int1, 0, "R1 int1"); chk(l_attn, 0, "R1 l_attn");
    rd(0, 512 + 2, 8'h00, "R1 send state idle");
    rd(1, 520, 8'h00, "R1 recv state idle");

    // R2: send buffer round trip and reply in place
    hw(3*32 + 5, 8'hA5);
    rd(1, 3*32 + 5, 8'hA5, "R2 local sees host msg");
    lw(3*32 + 5, 8'h5A);
    rd(0, 3*32 + 5, 8'h5A, "R2 host sees reply");
    lw(256 + 6*32 + 31, 8'hC3);
    rd(0, 256 + 6*32 + 31, 8'hC3, "R2 recv buffer");
    rd(1, 0, 8'h00, "R2 untouched byte");

    // R12: same-cycle write and read returns old value, then new
    @(negedge clk); h_we = 1; h_addr = AW'(7); h_wdata = 8'h3C;
    begin item_t it; it.due = cyc + 1; it.port = 0; it.exp = 8'h00; it.tag = "R12 read-first"; sb.push_back(it); end
    @(negedge clk); h_we = 0;
    begin item_t it; it.due = cyc + 1; it.port = 0; it.exp = 8'h3C; it.tag = "R12 next-cycle data"; sb.push_back(it); end
    @(negedge clk);

    // R3: state sequence on send channel 1
    hw(513, 8'h01);
    rd(1, 513, 8'h01, "R3 NEW visible to local");
    lw(513, 8'h02);
    rd(0, 513, 8'h02, "R3 RCVD visible to host");
    chk(int0, 0, "R4 RCVD no int0");
    lw(513, 8'h77);
    rd(0, 513, 8'h77, "R3 arbitrary value stored");
    chk(int0, 0, "R4 arbitrary value no int0");

    // R4 / R8
    lw(513, 8'h03);
    chk(int0, 1, "R4 COMPLETE sets int0");
    chk(h_irq, 1, "R8 irq with int0");
    lw(522, 8'h03);
    chk(int1, 0, "R4 COMPLETE on recv no int1");

    // R7: write-one-to-clear per bit
    hw(528, 8'h02);
    chk(int0, 1, "R7 zero bit keeps int0");
    hw(528, 8'h01);
    chk(int0, 0, "R7 int0 cleared");
    chk(h_irq, 0, "R8 irq low");

    // R5
    lw(524, 8'h02);
    chk(int1, 0, "R5 RCVD on recv no int1");
    lw(524, 8'h01);
    chk(int1, 1, "R5 NEW sets int1");
    chk(h_irq, 1, "R8 irq with int1");
    rd(0, 528, 8'h02, "R5 status shows int1");
    hw(528, 8'h02);
    chk(int1, 0, "R7 int1 cleared");

    // R6: host writes of trigger values
    hw(512, 8'h03);
    chk(int0, 0, "R6 host COMPLETE no int0");
    hw(521, 8'h01);
    chk(int1, 0, "R6 host NEW no int1");
    chk(h_irq, 0, "R6 irq stays low");

    // R7: set wins over clear
    lw(514, 8'h03);
    both(528, 8'h01, 514, 8'h03);
    chk(int0, 1, "R7 set wins over clear");
    hw(528, 8'h03);
    chk(int0, 0, "R7 cleared after");

    // R9: doorbell
    ring();
    chk(l_attn, 1, "R9 doorbell sets attn");
    hw(528, 8'h04);
    chk(l_attn, 1, "R9 host cannot clear attn");
    rd(1, 528, 8'h04, "R9 status bit2");
    lw(528, 8'h04);
    chk(l_attn, 0, "R9 local clears attn");

    // R10: collisions
    both(40, 8'h77, 40, 8'h88);
    rd(0, 40, 8'h88, "R10 buffer local wins");
    both(515, 8'h01, 515, 8'h02);
    rd(0, 515, 8'h02, "R10 state local wins");

    // R11: unmapped
    hw(224, 8'hFF);
    rd(0, 224, 8'h00, "R11 buffer slot 7");
    lw(519, 8'h03);
    chk(int0, 0, "R11 slot 7 COMPLETE no int0");
    rd(1, 519, 8'h00, "R11 state slot 7");
    hw(600, 8'h5F);
    rd(0, 600, 8'h00, "R11 unmapped address");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule